// File: doc/BRIEF.md
# Eight-Channel Serial Register Front-End

This block sits between a host register bus and eight external UART register banks on a multi-port serial adapter. The adapter occupies one 64-byte window on the host bus, and each bank has eight byte addresses in it. The front-end decodes the address and raises the chip select of the addressed bank. It passes the 3-bit register offset, the strobes and the write data through to that bank, and it returns the bank's read data to the host. Reads that fall outside the window return zero.

The front-end also combines the eight interrupt requests into one shared, level-sensitive interrupt. Each request passes through one register stage before the requests are ORed together.

Unless a strap restores the UART scratchpad, offset 7 of every bank belongs to the front-end. A read there returns a live vector of pending interrupt requests. A write there sets a 2-bit reference-clock ratio. The ratio drives a clock-select output that picks ×1, ×2, ×4 or ×8 of a 1.8432 MHz base. Hardware straps can force a faster ratio over the value software has written.

Top module: `serial_window_frontend`

## Requirements
- R1: An access with the strobe high at address WINDOW_BASE + 8·(n−1) + k, where n is 1..8 and k is 0..6, asserts only port_cs bit n−1. During that access port_offs equals k, port_rd or port_wr follows the matching strobe, and port_wdata equals wdata.
- R2: A read inside a bank returns the selected bank's 8-bit slice of port_rdata on rdata in the same cycle (bank n uses bits 8·(n−1)+7 down to 8·(n−1)). A read outside the 64-byte window returns zero and asserts no chip select and no port strobe.
- R3: irq_out goes high on the clock edge after any port_irq bit is sampled high. It stays high while any bit remains high, and it goes low on the edge after all bits are sampled low.
- R4: When strap_spad_en is low, a read at offset 7 of any bank asserts no chip select. It returns a status byte in which bit n−1 is port n's request, as registered at the last clock edge. Reading does not clear the status byte.
- R5: When strap_spad_en is low, a write at offset 7 of any bank loads wdata[1:0] into the ratio field (00 = ×1, 01 = ×2, 10 = ×4, 11 = ×8) at the clock edge and asserts no chip select. clk_ratio shows the new value after that edge, as long as no ratio strap is active.
- R6: When strap_spad_en is high, offset 7 accesses go to the addressed bank with port_offs = 7, like any other offset. A write there leaves the ratio field unchanged.
- R7: After reset the ratio field is ×1, so clk_ratio is 00 when no strap is active, and irq_out is low.
- R8: While strap_x2, strap_x4 or strap_x8 is high, clk_ratio shows that ratio (01, 10 or 11) whatever software has written. If several are high, the highest ratio wins. Once all three straps are low, clk_ratio returns to the software value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (10) | Host byte address |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| wdata | input | DATA_W (8) | Host write data |
| rdata | output | DATA_W (8) | Host read data |
| port_cs | output | NUM_PORTS (8) | Per-bank chip selects |
| port_offs | output | OFFS_W (3) | Register offset within the bank |
| port_rd | output | 1 | Read strobe to the selected bank |
| port_wr | output | 1 | Write strobe to the selected bank |
| port_wdata | output | DATA_W (8) | Write data to the banks |
| port_rdata | input | NUM_PORTS·DATA_W (64) | Read data from all banks, bank n in slice n−1 |
| port_irq | input | NUM_PORTS (8) | Per-bank interrupt requests |
| strap_spad_en | input | 1 | Gives offset 7 back to the UART scratchpads |
| strap_x2 | input | 1 | Forces the ×2 ratio |
| strap_x4 | input | 1 | Forces the ×4 ratio |
| strap_x8 | input | 1 | Forces the ×8 ratio |
| clk_ratio | output | 2 | Reference clock ratio select |
| irq_out | output | 1 | Shared level interrupt |

## Verification
The bench builds the block with its defaults: eight banks of eight byte registers, an 8-bit data path and a 10-bit address with the window at 0x100. Because the window sits in the middle of the address space, the bench can probe the bytes just below and just above it as well as every bank. With eight banks and an 8-bit status byte, each request has its own status bit. The bench can therefore check the status mapping bit by bit and check the ratio field against every strap combination.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // Reference clock ratio encoding shared by the options field and the output.
  typedef enum logic [1:0] {
    RATIO_X1 = 2'b00,
    RATIO_X2 = 2'b01,
    RATIO_X4 = 2'b10,
    RATIO_X8 = 2'b11
  } ratio_e;

endpackage

// File: rtl/sfe_addr_decode.sv
module sfe_addr_decode #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WINDOW_BASE = 'h100,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned OFFS_W      = 3,
  localparam int unsigned IDX_W      = $clog2(NUM_PORTS)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic                 spad_en,
  output logic [NUM_PORTS-1:0] port_cs,
  output logic [OFFS_W-1:0]    port_offs,
  output logic                 port_rd,
  output logic                 port_wr,
  output logic                 reg_rd,
  output logic                 reg_wr,
  output logic [IDX_W-1:0]     bank_idx
);

  localparam int unsigned WIN_W = IDX_W + OFFS_W;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WINDOW_BASE);
  localparam logic [OFFS_W-1:0] SPECIAL_OFFS = '1;

  logic in_window;
  logic special;
  logic access;
  logic bank_hit;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_W] == BASE_V[ADDR_W-1:WIN_W]);
    bank_idx  = addr[WIN_W-1:OFFS_W];
    port_offs = addr[OFFS_W-1:0];
    special   = in_window && (port_offs == SPECIAL_OFFS) && !spad_en;
    access    = rd_stb || wr_stb;
    bank_hit  = in_window && !special && access;
    port_rd   = bank_hit && rd_stb;
    port_wr   = bank_hit && wr_stb;
    reg_rd    = special && rd_stb;
    reg_wr    = special && wr_stb;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_cs
    assign port_cs[i] = bank_hit && (bank_idx == IDX_W'(i));
  end

endmodule

// File: rtl/sfe_irq_merge.sv
module sfe_irq_merge #(
  parameter int unsigned NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] irq_in,
  output logic [NUM_PORTS-1:0] irq_q,
  output logic                 irq_any
);

  logic [NUM_PORTS-1:0] irq_d;

  always_comb begin
    irq_d = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  // Only registered values feed the OR, so the shared line has no input glitches.
  assign irq_any = |irq_q;

endmodule

// File: rtl/sfe_ratio_select.sv
module sfe_ratio_select
  import sfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_ratio,
  input  logic       strap_x2,
  input  logic       strap_x4,
  input  logic       strap_x8,
  output logic [1:0] ratio
);

  ratio_e opt_q;
  ratio_e opt_d;

  always_comb begin
    opt_d = opt_q;
    if (wr_en) begin
      opt_d = ratio_e'(wr_ratio);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= RATIO_X1;
    end else begin
      opt_q <= opt_d;
    end
  end

  // Straps override software; the fastest active strap takes priority.
  always_comb begin
    if (strap_x8) begin
      ratio = RATIO_X8;
    end else if (strap_x4) begin
      ratio = RATIO_X4;
    end else if (strap_x2) begin
      ratio = RATIO_X2;
    end else begin
      ratio = opt_q;
    end
  end

endmodule

// File: rtl/serial_window_frontend.sv
module serial_window_frontend #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WINDOW_BASE = 'h100,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned OFFS_W      = 3,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        rd_stb,
  input  logic                        wr_stb,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_PORTS-1:0]        port_cs,
  output logic [OFFS_W-1:0]           port_offs,
  output logic                        port_rd,
  output logic                        port_wr,
  output logic [DATA_W-1:0]           port_wdata,
  input  logic [NUM_PORTS*DATA_W-1:0] port_rdata,
  input  logic [NUM_PORTS-1:0]        port_irq,
  input  logic                        strap_spad_en,
  input  logic                        strap_x2,
  input  logic                        strap_x4,
  input  logic                        strap_x8,
  output logic [1:0]                  clk_ratio,
  output logic                        irq_out
);

  localparam int unsigned IDX_W = $clog2(NUM_PORTS);

  // Reset is asserted asynchronously and released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  logic             reg_rd;
  logic             reg_wr;
  logic [IDX_W-1:0] bank_idx;
  logic [NUM_PORTS-1:0] irq_q;

  sfe_addr_decode #(
    .ADDR_W      (ADDR_W),
    .WINDOW_BASE (WINDOW_BASE),
    .NUM_PORTS   (NUM_PORTS),
    .OFFS_W      (OFFS_W)
  ) u_dec (
    .addr      (addr),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .spad_en   (strap_spad_en),
    .port_cs   (port_cs),
    .port_offs (port_offs),
    .port_rd   (port_rd),
    .port_wr   (port_wr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .bank_idx  (bank_idx)
  );

  sfe_irq_merge #(
    .NUM_PORTS (NUM_PORTS)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .irq_in  (port_irq),
    .irq_q   (irq_q),
    .irq_any (irq_out)
  );

  sfe_ratio_select u_ratio (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .wr_ratio (wdata[1:0]),
    .strap_x2 (strap_x2),
    .strap_x4 (strap_x4),
    .strap_x8 (strap_x8),
    .ratio    (clk_ratio)
  );

  assign port_wdata = wdata;

  // Per-bank read data slices.
  logic [DATA_W-1:0] bank_data [NUM_PORTS];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slice
    assign bank_data[i] = port_rdata[i*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata = '0;
    if (reg_rd) begin
      rdata = DATA_W'(irq_q);
    end else if (port_rd) begin
      rdata = bank_data[bank_idx];
    end
  end

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WINDOW_BASE = 'h100,
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned OFFS_W      = 3,
  parameter int unsigned DATA_W      = 8
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 rd_stb,
  input logic                 wr_stb,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_PORTS-1:0] port_cs,
  input logic                 port_rd,
  input logic                 port_wr,
  input logic [NUM_PORTS-1:0] port_irq,
  input logic                 strap_spad_en,
  input logic                 strap_x2,
  input logic                 strap_x4,
  input logic                 strap_x8,
  input logic [1:0]           clk_ratio,
  input logic                 irq_out
);

  localparam int unsigned WIN_W = $clog2(NUM_PORTS) + OFFS_W;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WINDOW_BASE);

  logic outside;
  logic offs7;
  logic [2:0] straps;

  assign outside = (addr[ADDR_W-1:WIN_W] != BASE_V[ADDR_W-1:WIN_W]);
  assign offs7   = !outside && (addr[OFFS_W-1:0] == '1);
  assign straps  = {strap_x8, strap_x4, strap_x2};

  // R1: at most one bank selected, and its strobe only with a chip select
  p_onehot_cs_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(port_cs) && ((port_rd || port_wr) == (port_cs != '0)));

  // R2: reads outside the window select nothing and return zero
  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_stb && outside) |-> (rdata == '0 && port_cs == '0));

  // R3: the shared line follows the requests one edge later
  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (port_irq != '0) |=> irq_out);

  p_irq_clr_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (port_irq == '0) |=> !irq_out);

  // R4: the status register at offset 7 takes no bank
  p_special_no_cs_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (offs7 && !strap_spad_en && (rd_stb || wr_stb)) |-> (port_cs == '0));

  // R6: with the scratchpad strap, offset 7 selects a bank
  p_spad_cs_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (offs7 && strap_spad_en && (rd_stb || wr_stb)) |-> (port_cs != '0));

  // R8: the x8 strap always wins
  p_x8_wins_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    strap_x8 |-> (clk_ratio == 2'b11));

  // R5: without a ratio write and with steady straps, the ratio holds
  p_ratio_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_stb && offs7 && !strap_spad_en) |=> ($stable(straps) -> $stable(clk_ratio)));

endmodule

bind serial_window_frontend sfe_checker #(
  .ADDR_W      (ADDR_W),
  .WINDOW_BASE (WINDOW_BASE),
  .NUM_PORTS   (NUM_PORTS),
  .OFFS_W      (OFFS_W),
  .DATA_W      (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .addr          (addr),
  .rd_stb        (rd_stb),
  .wr_stb        (wr_stb),
  .rdata         (rdata),
  .port_cs       (port_cs),
  .port_rd       (port_rd),
  .port_wr       (port_wr),
  .port_irq      (port_irq),
  .strap_spad_en (strap_spad_en),
  .strap_x2      (strap_x2),
  .strap_x4      (strap_x4),
  .strap_x8      (strap_x8),
  .clk_ratio     (clk_ratio),
  .irq_out       (irq_out)
);

// File: tb/sim_serial_window_frontend.sv
`timescale 1ns/1ps
module sim_serial_window_frontend;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned BASE   = 'h100;
  localparam int unsigned NP     = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [ADDR_W-1:0] addr;
  logic            rd_stb, wr_stb;
  logic [7:0]      wdata, rdata;
  logic [NP-1:0]   port_cs;
  logic [2:0]      port_offs;
  logic            port_rd, port_wr;
  logic [7:0]      port_wdata;
  logic [NP*8-1:0] port_rdata;
  logic [NP-1:0]   port_irq;
  logic            strap_spad_en, strap_x2, strap_x4, strap_x8;
  logic [1:0]      clk_ratio;
  logic            irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < NP; i++) begin : g_bank
    assign port_rdata[i*8 +: 8] = 8'hA0 + 8'(i);
  end

  serial_window_frontend u0 (
    .clk (clk), .rst_n (rst_n), .addr (addr), .rd_stb (rd_stb), .wr_stb (wr_stb),
    .wdata (wdata), .rdata (rdata), .port_cs (port_cs), .port_offs (port_offs),
    .port_rd (port_rd), .port_wr (port_wr), .port_wdata (port_wdata),
    .port_rdata (port_rdata), .port_irq (port_irq), .strap_spad_en (strap_spad_en),
    .strap_x2 (strap_x2), .strap_x4 (strap_x4), .strap_x8 (strap_x8),
    .clk_ratio (clk_ratio), .irq_out (irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic t_reset();
    check("R7 clk_ratio after reset", 32'(clk_ratio), 32'h0);
    check("R7 irq_out after reset", 32'(irq_out), 32'h0);
  endtask

  task automatic t_bank_access();
    int offs [3] = '{0, 3, 6};
    for (int n = 0; n < NP; n++) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        addr = ADDR_W'(BASE + 8*n + offs[j]); rd_stb = 1'b1; wr_stb = 1'b0;
        #1;
        check("R1 read cs", 32'(port_cs), 32'(1 << n));
        check("R1 offs", 32'(port_offs), 32'(offs[j]));
        check("R1 port_rd", 32'({port_rd, port_wr}), 32'h2);
        check("R2 bank rdata", 32'(rdata), 32'(8'hA0 + n));
      end
      @(negedge clk);
      addr = ADDR_W'(BASE + 8*n + 5); rd_stb = 1'b0; wr_stb = 1'b1; wdata = 8'h5A ^ 8'(n);
      #1;
      check("R1 write cs", 32'(port_cs), 32'(1 << n));
      check("R1 port_wr", 32'({port_rd, port_wr}), 32'h1);
      check("R1 wdata pass", 32'(port_wdata), 32'(8'h5A ^ 8'(n)));
    end
    idle();
  endtask

  task automatic t_outside();
    int probes [2] = '{BASE - 1, BASE + 64};
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      addr = ADDR_W'(probes[j]); rd_stb = 1'b1;
      #1;
      check("R2 outside rdata", 32'(rdata), 32'h0);
      check("R2 outside cs", 32'({port_cs, port_rd}), 32'h0);
    end
    idle();
  endtask

  task automatic t_irq();
    @(negedge clk);
    port_irq = 8'b1000_0101;
    #1;
    check("R3 no change before edge", 32'(irq_out), 32'h0);
    @(posedge clk); #1;
    check("R3 irq set", 32'(irq_out), 32'h1);
    @(negedge clk);
    addr = ADDR_W'(BASE + 8*3 + 7); rd_stb = 1'b1;
    #1;
    check("R4 status read", 32'(rdata), 32'h85);
    check("R4 no cs on status", 32'({port_cs, port_rd}), 32'h0);
    @(negedge clk);
    addr = ADDR_W'(BASE + 7);
    #1;
    check("R4 status not cleared", 32'(rdata), 32'h85);
    @(negedge clk);
    port_irq = 8'b0000_0000;
    #1;
    check("R3 level held until edge", 32'(irq_out), 32'h1);
    check("R4 status still registered", 32'(rdata), 32'h85);
    @(posedge clk); #1;
    check("R3 irq clear", 32'(irq_out), 32'h0);
    check("R4 status clear", 32'(rdata), 32'h0);
    idle();
  endtask

  task automatic t_options();
    @(negedge clk);
    addr = ADDR_W'(BASE + 8*2 + 7); wr_stb = 1'b1; wdata = 8'hFE;
    #1;
    check("R5 no cs on options write", 32'({port_cs, port_wr}), 32'h0);
    check("R5 ratio before edge", 32'(clk_ratio), 32'h0);
    @(posedge clk); #1;
    check("R5 ratio x4 written", 32'(clk_ratio), 32'h2);
    idle();
    #1;
    check("R5 ratio held", 32'(clk_ratio), 32'h2);
  endtask

  task automatic t_spad();
    @(negedge clk);
    strap_spad_en = 1'b1;
    addr = ADDR_W'(BASE + 7); wr_stb = 1'b1; wdata = 8'h03;
    #1;
    check("R6 spad write cs", 32'(port_cs), 32'h1);
    check("R6 spad offs", 32'(port_offs), 32'h7);
    @(posedge clk); #1;
    check("R6 ratio unchanged", 32'(clk_ratio), 32'h2);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b1; addr = ADDR_W'(BASE + 8*6 + 7);
    #1;
    check("R6 spad read data", 32'(rdata), 32'hA6);
    idle();
    strap_spad_en = 1'b0;
  endtask

  task automatic t_straps();
    @(negedge clk); strap_x2 = 1'b1; #1;
    check("R8 x2 strap", 32'(clk_ratio), 32'h1);
    @(negedge clk); strap_x8 = 1'b1; #1;
    check("R8 x8 beats x2", 32'(clk_ratio), 32'h3);
    @(negedge clk); strap_x8 = 1'b0; strap_x4 = 1'b1; #1;
    check("R8 x4 beats x2", 32'(clk_ratio), 32'h2);
    @(negedge clk); addr = ADDR_W'(BASE + 7); wr_stb = 1'b1; wdata = 8'h01;
    @(posedge clk); #1;
    check("R8 strap masks write", 32'(clk_ratio), 32'h2);
    idle();
    strap_x4 = 1'b0; strap_x2 = 1'b0; #1;
    check("R8 release to software", 32'(clk_ratio), 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; rd_stb = 1'b0; wr_stb = 1'b0; wdata = '0;
    port_irq = '0; strap_spad_en = 1'b0; strap_x2 = 1'b0; strap_x4 = 1'b0; strap_x8 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bank_access();
    t_outside();
    t_irq();
    t_options();
    t_spad();
    t_straps();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule